// File: doc/BRIEF.md
# FIFO-Buffered SPI Master Controller

This block is a register-mapped SPI master. Software writes words to a data register. The words queue in a transmit FIFO and leave one frame at a time on the serial output, clocked by a serial clock built from a programmable divider. At the same time, bits arriving on the serial input, or on the block's own output when internal loopback is on, are gathered into a frame and queued in a receive FIFO. Software drains that FIFO through the same data register.

Software programs the block through three control words:
- the first holds clock polarity, clock phase, bit order, loopback, select polarity, operating mode and frame format;
- the second holds the divider, the frame length (stored as length minus one) and a stored padding field;
- the third holds core enable, separate transmit and receive enables, the output-drive enable, the select index and select level, and self-clearing bits that clear either FIFO or reset the core.

A status word reports how full the FIFOs are and whether a frame is on the wire. Two read-only words report a fixed revision code and the build parameters.

Back-pressure is handled at the register level, not by stalling the bus. The transmit FIFO accepts a data write only while it is not full, and a write to a full FIFO is dropped. The shifter takes a word only when its start conditions hold. The receive FIFO accepts a finished frame only while it has room, and a frame that finds it full is dropped. A data read takes the head of the receive FIFO only when that FIFO holds an entry.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset:
  - status reads 0x2;
  - control word 2 (word 0x02) reads 0x200, so the select level is high;
  - word 0x18 reads 0x00011900;
  - word 0x19 reads {4'b0, 1, 1, 2'b0, TX depth-1 [23:16], RX depth-1 [15:8], data width-1 [7:0]}, which is 0x0C0F0F1F with default parameters;
  - interrupt words 0x04 and 0x05 read 0.
- R2: A frame carries control1[20:16]+1 bits, most significant bit first by default. In phase 0 the output bit is presented before the leading edge, and input is sampled on the leading edge. The received frame is right-aligned and zero-extended.
- R3: Each serial-clock half period lasts control1[15:0]+1 system clock cycles.
- R4: The serial clock idles at control0 bit1 (polarity). With control0 bit0 (phase) set, input is sampled on the trailing edge.
- R5: With control0 bit6 set, frames are shifted least significant bit first, in both directions.
- R6: With control0 bit7 set, the receive path takes the transmitted bit instead of the serial input.
- R7: A frame starts only when all of these hold:
  - core enable (control2 bit0) is set;
  - transmit enable (control2 bit8) is set;
  - control0[3:2] is 3;
  - control0[14:12] is 1;
  - the transmit FIFO is not empty.
- R8: A finished frame enters the receive FIFO only if receive enable (control2 bit7) is set and the FIFO is not full. Status bit0 reports a full receive FIFO, and bits[8:4] report its entry count.
- R9: A data write (word 0x06) to a full transmit FIFO is dropped. Status bit1 reports that the transmit FIFO is not full, and bits[16:12] report its entry count.
- R10: Reading the data word while the receive FIFO is empty returns 0 and leaves the status unchanged.
- R11: Writing control2 with bit3 set empties the transmit FIFO, and with bit2 set empties the receive FIFO, in one cycle. Both bits read back as 0.
- R12: While control2 bit1 is clear, the serial output stays low.
- R13: Select pin control2[11:10] drives control2 bit9 when control0 bit5 is set, and its inverse when bit5 is clear. The other pins sit at the inactive level, which is control0 bit5.
- R14: Status bit2 is set from the cycle a frame starts until its last clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_pin | output | NUM_SS | Select outputs |

## Verification
The bench runs loopback frames of several lengths, in both clock modes, and compares them through a scoreboard. A length decode that is off by one, or a wrong sampling edge, shows up as shifted or truncated words. A bench slave on the pins checks bit order and the phase-0 timing, so a reversed shifter or a late first bit gives mirrored or shifted bytes. The bench fills both FIFOs to their limits to catch:
- an overwrite when a write or frame meets a full FIFO;
- a lost count on a clear;
- a pop on an empty read, which would corrupt the status.

It also checks three gating rules: a wrong frame format or a clear transmit enable must not start a frame, a clear output enable must keep the output low, and a clear receive enable must capture nothing.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef enum logic [5:0] {
    REG_CR0   = 6'h00,
    REG_CR1   = 6'h01,
    REG_CR2   = 6'h02,
    REG_STAT  = 6'h03,
    REG_ICTL  = 6'h04,
    REG_ISTAT = 6'h05,
    REG_DATA  = 6'h06,
    REG_REV   = 6'h18,
    REG_FEAT  = 6'h19
  } reg_ofs_e;

  localparam logic [31:0] REV_CODE = 32'h0001_1900;
  localparam logic [1:0]  OPM_MASTER = 2'b11;
  localparam logic [2:0]  FMT_SPI = 3'd1;

  typedef struct packed {
    logic [2:0] fmt;
    logic       loopb;
    logic       lsb;
    logic       fspo;
    logic [1:0] opm;
    logic       cpol;
    logic       cpha;
  } mode_cfg_t;

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [W-1:0]               in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [W-1:0]               out_data,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign in_ready  = (level != CW'(DEPTH));
  assign out_valid = (level != '0);
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_engine.sv
module spi_engine #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              out_en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              loop_en,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [DIV_W-1:0]  div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy
);
  logic              busy_q, lead_q, sclk_q;
  logic [DIV_W-1:0]  hc;
  logic [LEN_W-1:0]  bitcnt, idx;
  logic [DATA_W-1:0] txw, rxacc, rx_next;
  logic              start, tick, sample_now, last, tx_bit, in_bit;

  assign start      = !busy_q && run && tx_en && tx_valid;
  assign tick       = busy_q && (hc == div);
  assign sample_now = tick && (lead_q == cpha);
  assign last       = tick && lead_q && (bitcnt == frame_len);
  assign idx        = lsb_first ? bitcnt : frame_len - bitcnt;
  assign tx_bit     = txw[idx];
  assign in_bit     = loop_en ? tx_bit : miso;

  always_comb begin
    rx_next = rxacc;
    if (sample_now) rx_next[idx] = in_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lead_q <= 1'b0;
      sclk_q <= 1'b0;
      hc     <= '0;
      bitcnt <= '0;
      txw    <= '0;
      rxacc  <= '0;
    end else if (!run) begin
      busy_q <= 1'b0;
      lead_q <= 1'b0;
      sclk_q <= cpol;
      hc     <= '0;
      bitcnt <= '0;
    end else if (!busy_q) begin
      sclk_q <= cpol;
      if (start) begin
        busy_q <= 1'b1;
        lead_q <= 1'b0;
        hc     <= '0;
        bitcnt <= '0;
        txw    <= tx_data;
        rxacc  <= '0;
      end
    end else if (tick) begin
      hc     <= '0;
      sclk_q <= ~sclk_q;
      lead_q <= ~lead_q;
      rxacc  <= rx_next;
      if (lead_q) begin
        if (bitcnt == frame_len) busy_q <= 1'b0;
        else                     bitcnt <= bitcnt + 1'b1;
      end
    end else begin
      hc <= hc + 1'b1;
    end
  end

  assign tx_ready = start;
  assign rx_valid = last && rx_en;
  assign rx_data  = rx_next;
  assign busy     = busy_q;
  assign sclk     = busy_q ? sclk_q : cpol;
  assign mosi     = out_en && busy_q && tx_bit;
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16,
  parameter int NUM_SS     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_pin
);
  localparam int LEN_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);
  localparam int SS_W  = $clog2(NUM_SS);

  mode_cfg_t        cr0;
  logic [DIV_W-1:0] cr1_div;
  logic [LEN_W-1:0] cr1_len;
  logic [7:0]       cr1_pad;
  logic             c2_en, c2_oe, c2_rxen, c2_txen, c2_lvl;
  logic [SS_W-1:0]  c2_sel;

  logic              wr_en, cr2_wr, tx_clr, rx_clr, soft_rst, run;
  logic              tx_push, rx_pop;
  logic              tx_in_ready, tx_out_valid, tx_pop;
  logic [DATA_W-1:0] tx_head;
  logic              rx_in_ready, rx_out_valid, eng_rx_valid;
  logic [DATA_W-1:0] rx_head, eng_rx_data;
  logic [CNT_W-1:0]  tx_lvl, rx_lvl;
  logic              eng_busy;
  wire               unused_bits = ^bus_wdata;

  assign wr_en    = bus_en && bus_we;
  assign cr2_wr   = wr_en && (bus_addr == REG_CR2);
  assign soft_rst = cr2_wr && bus_wdata[6];
  assign tx_clr   = cr2_wr && (bus_wdata[3] || bus_wdata[6]);
  assign rx_clr   = cr2_wr && (bus_wdata[2] || bus_wdata[6]);
  assign tx_push  = wr_en && (bus_addr == REG_DATA);
  assign rx_pop   = bus_en && !bus_we && (bus_addr == REG_DATA);
  assign run      = c2_en && (cr0.opm == OPM_MASTER) && (cr0.fmt == FMT_SPI) && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0     <= '0;
      cr1_div <= '0;
      cr1_len <= '0;
      cr1_pad <= '0;
      c2_en   <= 1'b0;
      c2_oe   <= 1'b0;
      c2_rxen <= 1'b0;
      c2_txen <= 1'b0;
      c2_lvl  <= 1'b1;
      c2_sel  <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        REG_CR0: begin
          cr0.cpha  <= bus_wdata[0];
          cr0.cpol  <= bus_wdata[1];
          cr0.opm   <= bus_wdata[3:2];
          cr0.fspo  <= bus_wdata[5];
          cr0.lsb   <= bus_wdata[6];
          cr0.loopb <= bus_wdata[7];
          cr0.fmt   <= bus_wdata[14:12];
        end
        REG_CR1: begin
          cr1_div <= bus_wdata[DIV_W-1:0];
          cr1_len <= bus_wdata[16 +: LEN_W];
          cr1_pad <= bus_wdata[31:24];
        end
        REG_CR2: begin
          c2_en   <= bus_wdata[0];
          c2_oe   <= bus_wdata[1];
          c2_rxen <= bus_wdata[7];
          c2_txen <= bus_wdata[8];
          c2_lvl  <= bus_wdata[9];
          c2_sel  <= bus_wdata[10 +: SS_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CR0: begin
        bus_rdata[0]     = cr0.cpha;
        bus_rdata[1]     = cr0.cpol;
        bus_rdata[3:2]   = cr0.opm;
        bus_rdata[5]     = cr0.fspo;
        bus_rdata[6]     = cr0.lsb;
        bus_rdata[7]     = cr0.loopb;
        bus_rdata[14:12] = cr0.fmt;
      end
      REG_CR1: begin
        bus_rdata[DIV_W-1:0]    = cr1_div;
        bus_rdata[16 +: LEN_W]  = cr1_len;
        bus_rdata[31:24]        = cr1_pad;
      end
      REG_CR2: begin
        bus_rdata[0]           = c2_en;
        bus_rdata[1]           = c2_oe;
        bus_rdata[7]           = c2_rxen;
        bus_rdata[8]           = c2_txen;
        bus_rdata[9]           = c2_lvl;
        bus_rdata[10 +: SS_W]  = c2_sel;
      end
      REG_STAT: begin
        bus_rdata[0]          = !rx_in_ready;
        bus_rdata[1]          = tx_in_ready;
        bus_rdata[2]          = eng_busy;
        bus_rdata[4 +: CNT_W] = rx_lvl;
        bus_rdata[12 +: CNT_W] = tx_lvl;
      end
      REG_DATA: if (rx_out_valid) bus_rdata[DATA_W-1:0] = rx_head;
      REG_REV:  bus_rdata = REV_CODE;
      REG_FEAT: begin
        bus_rdata[7:0]   = 8'(DATA_W-1);
        bus_rdata[15:8]  = 8'(FIFO_DEPTH-1);
        bus_rdata[23:16] = 8'(FIFO_DEPTH-1);
        bus_rdata[26]    = 1'b1;
        bus_rdata[27]    = 1'b1;
      end
      default: bus_rdata = '0;
    endcase
  end

  spi_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .in_valid(tx_push), .in_ready(tx_in_ready), .in_data(bus_wdata[DATA_W-1:0]),
    .out_valid(tx_out_valid), .out_ready(tx_pop), .out_data(tx_head),
    .level(tx_lvl)
  );

  spi_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .in_valid(eng_rx_valid), .in_ready(rx_in_ready), .in_data(eng_rx_data),
    .out_valid(rx_out_valid), .out_ready(rx_pop), .out_data(rx_head),
    .level(rx_lvl)
  );

  spi_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(run), .tx_en(c2_txen), .rx_en(c2_rxen),
    .out_en(c2_oe), .cpol(cr0.cpol), .cpha(cr0.cpha), .lsb_first(cr0.lsb),
    .loop_en(cr0.loopb), .frame_len(cr1_len), .div(cr1_div),
    .tx_valid(tx_out_valid), .tx_ready(tx_pop), .tx_data(tx_head),
    .rx_valid(eng_rx_valid), .rx_data(eng_rx_data),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(eng_busy)
  );

  for (genvar g = 0; g < NUM_SS; g++) begin : g_ss
    assign ss_pin[g] = (c2_sel == SS_W'(g)) ? (c2_lvl ^ ~cr0.fspo) : cr0.fspo;
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int NUM_SS     = 4,
  parameter int CNT_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              busy,
  input logic              cpol,
  input logic              fspo,
  input logic [NUM_SS-1:0] ss_pin,
  input logic [CNT_W-1:0]  tx_level,
  input logic [CNT_W-1:0]  rx_level,
  input logic              rx_en,
  input logic              tx_clr,
  input logic              core_en,
  input logic              tx_en
);
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CNT_W'(FIFO_DEPTH)); // R9
  AST_RX_ONLY_WHEN_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level > $past(rx_level)) |-> $past(rx_en)); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (tx_level == '0)); // R11
  AST_SCLK_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(cpol)) |-> $stable(sclk)); // R4
  AST_SS_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fspo ? ~ss_pin : ss_pin)); // R13
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(core_en && tx_en)); // R7
endmodule

bind spi_fifo_master spi_fifo_master_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .NUM_SS(NUM_SS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .busy(eng_busy), .cpol(cr0.cpol),
  .fspo(cr0.fspo), .ss_pin(ss_pin), .tx_level(tx_lvl), .rx_level(rx_lvl),
  .rx_en(c2_rxen), .tx_clr(tx_clr), .core_en(c2_en), .tx_en(c2_txen)
);

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  localparam logic [5:0] A_CR0 = 6'h00, A_CR1 = 6'h01, A_CR2 = 6'h02, A_STAT = 6'h03;
  localparam logic [5:0] A_ICTL = 6'h04, A_DATA = 6'h06, A_REV = 6'h18, A_FEAT = 6'h19;
  localparam logic [31:0] MST = 32'h100C, LOOP = 32'h80, LSB = 32'h40, FSPO = 32'h20;
  localparam logic [31:0] CPOL = 32'h2, CPHA = 32'h1;
  localparam logic [31:0] EN = 32'h1, OE = 32'h2, RXC = 32'h4, TXC = 32'h8;
  localparam logic [31:0] RXEN = 32'h80, TXEN = 32'h100, LVL = 32'h200;
  localparam logic [31:0] RUN = EN | OE | RXEN | TXEN;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk, mosi, miso;
  logic [3:0] ss_pin;

  spi_fifo_master u_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_pin(ss_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] exp_q[$];
  logic [7:0] slv_tx = 8'h00, slv_rx = 8'h00;
  int slv_idx = 7;
  logic mosi_hi = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (mosi) mosi_hi <= 1'b1;

  // bench slave, mode 0, msb first, on select pin 1
  always @(posedge sclk) if (!ss_pin[1]) slv_rx <= {slv_rx[6:0], mosi};
  always @(negedge sclk or posedge ss_pin[1]) begin
    if (ss_pin[1]) slv_idx <= 7;
    else if (slv_idx > 0) slv_idx <= slv_idx - 1;
  end
  assign miso = slv_tx[slv_idx[2:0]];

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 20000; i++) begin
      rd(A_STAT, st);
      if (!st[2] && st[16:12] == 0) break;
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [31:0] mask);
    wr(A_DATA, w);
    exp_q.push_back(w & mask);
  endtask

  task automatic drain(input string tag);
    logic [31:0] d, e;
    while (exp_q.size() > 0) begin
      rd(A_DATA, d);
      e = exp_q.pop_front();
      check(tag, d, e);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values and read-only words
    rd(A_STAT, d); check("R1 status", d, 32'h2);
    rd(A_CR2, d);  check("R1 cr2", d, 32'h200);
    rd(A_REV, d);  check("R1 rev", d, 32'h0001_1900);
    rd(A_FEAT, d); check("R1 feature", d, 32'h0C0F_0F1F);
    rd(A_ICTL, d); check("R1 ictl", d, 32'h0);
    check("R13 reset pins", {28'h0, ss_pin}, 32'h0);

    // R7 wrong format blocks start
    wr(A_CR0, 32'h000C | LOOP);
    wr(A_CR1, 32'h0007_0000);
    wr(A_CR2, RUN | LVL);
    wr(A_DATA, 32'h5A);
    repeat (40) @(negedge clk);
    rd(A_STAT, d); check("R7 no start bad format", d, 32'h1002);
    wr(A_CR0, MST | LOOP);
    exp_q.push_back(32'h5A);
    wait_idle(); drain("R6 loopback 8b");

    // R2 12-bit loopback frames
    wr(A_CR1, 32'h000B_0001);
    send(32'hABCDE, 32'hFFF); send(32'h123, 32'hFFF);
    send(32'hFFF, 32'hFFF);   send(32'h800, 32'hFFF);
    wait_idle(); drain("R2 12b frames");

    // R4 polarity 1 phase 1, 16-bit
    wr(A_CR0, MST | LOOP | CPOL | CPHA);
    wr(A_CR1, 32'h000F_0000);
    send(32'hBEEF, 32'hFFFF); send(32'h0001, 32'hFFFF); send(32'h8000, 32'hFFFF);
    wait_idle();
    check("R4 sclk idle high", {31'h0, sclk}, 32'h1);
    drain("R4 mode3 frames");

    // R3 divider, R14 busy
    wr(A_CR0, MST | LOOP);
    wr(A_CR1, 32'h0007_0002);
    send(32'h3C, 32'hFF);
    @(posedge sclk); c0 = cyc;
    @(posedge sclk); c1 = cyc;
    check("R3 sclk period", 32'(c1 - c0), 32'd6);
    rd(A_STAT, d); check("R14 busy mid frame", {31'h0, d[2]}, 32'h1);
    wait_idle();
    rd(A_STAT, d); check("R14 busy clear after", {31'h0, d[2]}, 32'h0);
    drain("R3 frame data");

    // R8 receive FIFO full and drop
    wr(A_CR1, 32'h0007_0000);
    for (int i = 0; i < 16; i++) send(32'(i * 17 + 3), 32'hFF);
    wait_idle();
    rd(A_STAT, d); check("R8 rx full", d, 32'h103);
    wr(A_DATA, 32'h77);
    wait_idle();
    rd(A_STAT, d); check("R8 full drop", d, 32'h103);
    drain("R8 rx order");
    rd(A_DATA, d); check("R10 empty read", d, 32'h0);
    rd(A_STAT, d); check("R10 status unchanged", d, 32'h2);

    // R8 receive disabled
    wr(A_CR2, EN | OE | TXEN | LVL);
    wr(A_DATA, 32'h11); wr(A_DATA, 32'h22);
    wait_idle();
    rd(A_STAT, d); check("R8 rx disabled", d, 32'h2);

    // R9 transmit full, R7 tx enable, R11 clear
    wr(A_CR2, EN | OE | RXEN | LVL);
    for (int i = 0; i < 17; i++) wr(A_DATA, 32'(i));
    rd(A_STAT, d); check("R9 tx full no start", d, 32'h1_0000);
    wr(A_CR2, EN | OE | RXEN | LVL | TXC);
    rd(A_STAT, d); check("R11 tx clear", d, 32'h2);
    rd(A_CR2, d);  check("R11 clear bit reads 0", d, 32'h283);
    wr(A_CR2, RUN | LVL);
    wr(A_DATA, 32'h42);
    wait_idle();
    rd(A_STAT, d); check("R11 rx loaded", d, 32'h12);
    wr(A_CR2, RUN | LVL | RXC);
    rd(A_STAT, d); check("R11 rx clear", d, 32'h2);

    // R13 select pins, R2 mode 0 on pins
    wr(A_CR0, MST | FSPO);
    wr(A_CR1, 32'h0007_0001);
    wr(A_CR2, EN | OE | RXEN | LVL | (32'd3 << 10));
    check("R13 idle high", {28'h0, ss_pin}, 32'hF);
    wr(A_CR2, EN | OE | RXEN | (32'd3 << 10));
    check("R13 pin3 active", {28'h0, ss_pin}, 32'h7);
    slv_tx = 8'hC5;
    wr(A_CR2, EN | OE | RXEN | LVL | (32'd1 << 10));
    wr(A_CR2, RUN | (32'd1 << 10));
    check("R13 pin1 active", {28'h0, ss_pin}, 32'hD);
    wr(A_DATA, 32'hA7);
    wait_idle();
    check("R2 slave got msb first", {24'h0, slv_rx}, 32'hA7);
    rd(A_DATA, d); check("R2 mode0 receive", d, 32'hC5);
    wr(A_CR2, RUN | LVL | (32'd1 << 10));

    // R5 lsb first
    wr(A_CR0, MST | FSPO | LSB);
    slv_tx = 8'h1D;
    wr(A_CR2, RUN | (32'd1 << 10));
    wr(A_DATA, 32'hB4);
    wait_idle();
    check("R5 lsb out", {24'h0, slv_rx}, {24'h0, rev8(8'hB4)});
    rd(A_DATA, d); check("R5 lsb in", d, {24'h0, rev8(8'h1D)});
    wr(A_CR2, RUN | LVL | (32'd1 << 10));

    // R12 output drive disabled
    wr(A_CR0, MST | FSPO);
    wr(A_CR2, EN | RXEN | TXEN | (32'd1 << 10));
    mosi_hi = 0;
    wr(A_DATA, 32'hFF);
    wait_idle();
    check("R12 slave saw zero", {24'h0, slv_rx}, 32'h0);
    check("R12 mosi never high", {31'h0, mosi_hi}, 32'h0);
    rd(A_DATA, d);
    wr(A_CR2, EN | RXEN | TXEN | LVL | (32'd1 << 10));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule